// File: doc/BRIEF.md
# Tagged Address Translation Cache with Protection Check

This block holds a small set of recent page translations and resolves a virtual address against all of them in the same cycle. A 16-bit virtual address splits into a 6-bit page number (bits 15:10) and a 10-bit in-page offset (bits 9:0). Each stored translation carries the page number, a 4-bit process tag, a 6-bit frame number, a writable flag and a present flag. A lookup hits only when the page number and the current process tag both match a slot in use. On a clean hit the physical address is the stored frame number placed above the unchanged offset.

Before any translation result is used, the page number is compared against a page-table length limit. Beyond that check, the lookup can end in four ways: the translation is missing, the page is not present, a write targets a read-only page, or it succeeds. The outcome is registered and appears one cycle after the request. An external refill port installs translations. A flush input empties the whole cache, and flush wins over a refill in the same cycle. When every slot is in use, a round-robin pointer picks the slot to overwrite.

Top module: `tlb_xlate`

## Requirements
- R1: On a clean hit, respPaddr equals the stored 6-bit frame number in bits 15:10 and lookupVaddr[9:0] unchanged in bits 9:0, and respHit is 1.
- R2: A stored translation hits only when its process tag equals curPid. The same page looked up under another tag gives respMiss.
- R3: When no slot in use holds the page number and tag, respMiss is 1 and respPaddr is 0.
- R4: When lookupVaddr[15:10] is greater than or equal to pageLimit (7 bits, 0 to 64), respBoundErr is the only flag raised, whatever the cache holds. A page number one below the limit is translated normally.
- R5: A hit on a translation whose present flag is 0 gives respPageFault, with respPaddr 0.
- R6: A write (lookupWrite=1) that hits a present translation with writable flag 0 gives respProtErr. A read of the same page hits.
- R7: respValid is 1 exactly in the cycle after a cycle with lookupValid=1. When it is 1, exactly one of respHit, respMiss, respBoundErr, respPageFault and respProtErr is 1. When it is 0, all flags are 0.
- R8: flushAll empties every slot at the next edge. A refill in the same cycle is discarded, so every later lookup misses until new refills arrive.
- R9: A refill whose page number and tag already sit in a slot overwrites that slot in place. The round-robin pointer does not move and no other slot changes.
- R10: A refill of a new translation goes into the lowest-numbered free slot while any slot is free.
- R11: A new translation with all slots in use replaces the slot at the round-robin pointer. The pointer starts at 0, advances by one on each such replacement and wraps from 15 to 0.
- R12: After reset all slots are empty and every response output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| lookupValid | input | 1 | Translate lookupVaddr this cycle |
| lookupVaddr | input | 16 | Virtual address: page number 15:10, offset 9:0 |
| lookupWrite | input | 1 | 1 for a write access, 0 for a read |
| curPid | input | 4 | Process tag of the running process |
| pageLimit | input | 7 | Number of legal page numbers |
| flushAll | input | 1 | Empty the whole cache |
| refillValid | input | 1 | Install the refill translation |
| refillVpn | input | 6 | Page number to install |
| refillPid | input | 4 | Process tag to install |
| refillPfn | input | 6 | Frame number to install |
| refillWritable | input | 1 | 1 if writes are allowed |
| refillPresent | input | 1 | 1 if the page is resident |
| respValid | output | 1 | A lookup result is present |
| respPaddr | output | 16 | Physical address on a clean hit, else 0 |
| respHit | output | 1 | Clean translation |
| respMiss | output | 1 | No matching translation |
| respBoundErr | output | 1 | Page number at or beyond pageLimit |
| respPageFault | output | 1 | Matching translation not present |
| respProtErr | output | 1 | Write to a read-only page |

## Verification
The assertions assume that lookup inputs stay stable across the cycle in which lookupValid is high. They also assume that flushAll, refillValid and lookupValid are never unknown once reset is released. The bench changes inputs only on falling edges and holds all strobes at 0 from time zero, so both assumptions hold. It keeps its own model of slot contents and of the replacement pointer, built from R9 to R11. It then sweeps every page number under both access types and compares each registered result with that model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_ENTRIES = 16;
  localparam int TLB_VA_W    = 16;
  localparam int TLB_OFF_W   = 10;
  localparam int TLB_PID_W   = 4;
  localparam int TLB_PFN_W   = 6;

  // Strobes from control to datapath
  typedef struct packed {
    logic flush;      // empty every slot
    logic install;    // write refill fields into the chosen slot
    logic useVictim;  // the chosen slot came from the round-robin pointer
  } tlbStrobes_t;

  typedef enum logic [2:0] {
    RES_NONE   = 3'd0,
    RES_HIT    = 3'd1,
    RES_MISS   = 3'd2,
    RES_BOUND  = 3'd3,
    RES_PFAULT = 3'd4,
    RES_PROT   = 3'd5
  } tlbResult_e;
endpackage

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES,
  parameter int VA_W    = TLB_VA_W,
  parameter int OFF_W   = TLB_OFF_W,
  parameter int PID_W   = TLB_PID_W,
  parameter int PFN_W   = TLB_PFN_W,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobes_t        strobes,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PID_W-1:0]   refillPid,
  input  logic [PFN_W-1:0]   refillPfn,
  input  logic               refillWritable,
  input  logic               refillPresent,
  input  logic [VPN_W-1:0]   lookupVpn,
  input  logic [PID_W-1:0]   lookupPid,
  output logic [ENTRIES-1:0] hitVec,
  output logic [ENTRIES-1:0] refMatchVec,
  output logic [ENTRIES-1:0] usedVec,
  output logic [PFN_W-1:0]   hitPfn,
  output logic               hitWritable,
  output logic               hitPresent
);
  logic [VPN_W-1:0] entVpn  [ENTRIES];
  logic [PID_W-1:0] entPid  [ENTRIES];
  logic [PFN_W-1:0] entPfn  [ENTRIES];
  logic             entWr   [ENTRIES];
  logic             entPres [ENTRIES];
  logic             entUsed [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        entUsed[g] <= 1'b0;
        entVpn[g]  <= '0;
        entPid[g]  <= '0;
        entPfn[g]  <= '0;
        entWr[g]   <= 1'b0;
        entPres[g] <= 1'b0;
      end else if (strobes.flush) begin
        entUsed[g] <= 1'b0;
      end else if (strobes.install && (wrIdx == IDX_W'(g))) begin
        entUsed[g] <= 1'b1;
        entVpn[g]  <= refillVpn;
        entPid[g]  <= refillPid;
        entPfn[g]  <= refillPfn;
        entWr[g]   <= refillWritable;
        entPres[g] <= refillPresent;
      end
    end

    // parallel compare, one comparator pair per slot
    assign hitVec[g]      = entUsed[g] && (entVpn[g] == lookupVpn) && (entPid[g] == lookupPid);
    assign refMatchVec[g] = entUsed[g] && (entVpn[g] == refillVpn) && (entPid[g] == refillPid);
    assign usedVec[g]     = entUsed[g];
  end

  // at most one slot matches, so an OR of masked fields selects it
  always_comb begin
    hitPfn      = '0;
    hitWritable = 1'b0;
    hitPresent  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      hitPfn      = hitPfn | ({PFN_W{hitVec[i]}} & entPfn[i]);
      hitWritable = hitWritable | (hitVec[i] & entWr[i]);
      hitPresent  = hitPresent | (hitVec[i] & entPres[i]);
    end
  end
endmodule

// File: rtl/tlb_control.sv
module tlb_control
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES,
  parameter int VA_W    = TLB_VA_W,
  parameter int OFF_W   = TLB_OFF_W,
  parameter int PFN_W   = TLB_PFN_W,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flushAll,
  input  logic               refillValid,
  input  logic               lookupValid,
  input  logic               lookupWrite,
  input  logic [VA_W-1:0]    lookupVaddr,
  input  logic [VPN_W:0]     pageLimit,
  input  logic [ENTRIES-1:0] hitVec,
  input  logic [ENTRIES-1:0] refMatchVec,
  input  logic [ENTRIES-1:0] usedVec,
  input  logic [PFN_W-1:0]   hitPfn,
  input  logic               hitWritable,
  input  logic               hitPresent,
  output tlbStrobes_t        strobes,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               respValid,
  output logic [PA_W-1:0]    respPaddr,
  output logic               respHit,
  output logic               respMiss,
  output logic               respBoundErr,
  output logic               respPageFault,
  output logic               respProtErr
);
  function automatic logic [IDX_W-1:0] lowestSet(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [IDX_W-1:0] rrPtr;
  logic             anyMatch;
  logic             anyFree;

  assign anyMatch = |refMatchVec;
  assign anyFree  = ~&usedVec;

  always_comb begin
    strobes.flush     = flushAll;
    strobes.install   = refillValid && !flushAll;
    strobes.useVictim = refillValid && !flushAll && !anyMatch && !anyFree;
    if (anyMatch)     wrIdx = lowestSet(refMatchVec);
    else if (anyFree) wrIdx = lowestSet(~usedVec);
    else              wrIdx = rrPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strobes.useVictim) begin
      if (rrPtr == IDX_W'(ENTRIES - 1)) rrPtr <= '0;
      else                              rrPtr <= rrPtr + 1'b1;
    end
  end

  // classify the lookup: bound check first, then miss, fault, protection
  tlbResult_e       nextKind;
  logic [VPN_W-1:0] lookupVpn;
  logic             outOfRange;

  assign lookupVpn  = lookupVaddr[VA_W-1:OFF_W];
  assign outOfRange = ({1'b0, lookupVpn} >= pageLimit);

  always_comb begin
    if (!lookupValid)              nextKind = RES_NONE;
    else if (outOfRange)           nextKind = RES_BOUND;
    else if (~|hitVec)             nextKind = RES_MISS;
    else if (!hitPresent)          nextKind = RES_PFAULT;
    else if (lookupWrite && !hitWritable) nextKind = RES_PROT;
    else                           nextKind = RES_HIT;
  end

  tlbResult_e kindQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ     <= RES_NONE;
      respPaddr <= '0;
    end else begin
      kindQ     <= nextKind;
      respPaddr <= (nextKind == RES_HIT) ? {hitPfn, lookupVaddr[OFF_W-1:0]} : '0;
    end
  end

  assign respValid     = (kindQ != RES_NONE);
  assign respHit       = (kindQ == RES_HIT);
  assign respMiss      = (kindQ == RES_MISS);
  assign respBoundErr  = (kindQ == RES_BOUND);
  assign respPageFault = (kindQ == RES_PFAULT);
  assign respProtErr   = (kindQ == RES_PROT);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ENTRIES = TLB_ENTRIES,
  parameter int VA_W    = TLB_VA_W,
  parameter int OFF_W   = TLB_OFF_W,
  parameter int PID_W   = TLB_PID_W,
  parameter int PFN_W   = TLB_PFN_W,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVaddr,
  input  logic             lookupWrite,
  input  logic [PID_W-1:0] curPid,
  input  logic [VPN_W:0]   pageLimit,
  input  logic             flushAll,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PID_W-1:0] refillPid,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic             refillWritable,
  input  logic             refillPresent,
  output logic             respValid,
  output logic [PA_W-1:0]  respPaddr,
  output logic             respHit,
  output logic             respMiss,
  output logic             respBoundErr,
  output logic             respPageFault,
  output logic             respProtErr
);
  tlbStrobes_t        strobes;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] refMatchVec;
  logic [ENTRIES-1:0] usedVec;
  logic [PFN_W-1:0]   hitPfn;
  logic               hitWritable;
  logic               hitPresent;

  tlb_datapath #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PID_W(PID_W), .PFN_W(PFN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrIdx(wrIdx),
    .refillVpn(refillVpn), .refillPid(refillPid), .refillPfn(refillPfn),
    .refillWritable(refillWritable), .refillPresent(refillPresent),
    .lookupVpn(lookupVaddr[VA_W-1:OFF_W]), .lookupPid(curPid),
    .hitVec(hitVec), .refMatchVec(refMatchVec), .usedVec(usedVec),
    .hitPfn(hitPfn), .hitWritable(hitWritable), .hitPresent(hitPresent)
  );

  tlb_control #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .flushAll(flushAll), .refillValid(refillValid),
    .lookupValid(lookupValid), .lookupWrite(lookupWrite), .lookupVaddr(lookupVaddr),
    .pageLimit(pageLimit), .hitVec(hitVec), .refMatchVec(refMatchVec),
    .usedVec(usedVec), .hitPfn(hitPfn), .hitWritable(hitWritable),
    .hitPresent(hitPresent), .strobes(strobes), .wrIdx(wrIdx),
    .respValid(respValid), .respPaddr(respPaddr), .respHit(respHit),
    .respMiss(respMiss), .respBoundErr(respBoundErr),
    .respPageFault(respPageFault), .respProtErr(respProtErr)
  );
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W   = 16,
  parameter int OFF_W  = 10,
  parameter int PFN_W  = 6,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input logic            clk,
  input logic            rstN,
  input logic            lookupValid,
  input logic [VA_W-1:0] lookupVaddr,
  input logic            lookupWrite,
  input logic [VPN_W:0]  pageLimit,
  input logic            flushAll,
  input logic            respValid,
  input logic [PA_W-1:0] respPaddr,
  input logic            respHit,
  input logic            respMiss,
  input logic            respBoundErr,
  input logic            respPageFault,
  input logic            respProtErr
);
  // R7
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid == $past(lookupValid));

  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({respHit, respMiss, respBoundErr, respPageFault, respProtErr}) == (respValid ? 1 : 0));

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    respHit |-> (respPaddr[OFF_W-1:0] == $past(lookupVaddr[OFF_W-1:0])));

  // R4
  bound_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && ({1'b0, $past(lookupVaddr[VA_W-1:OFF_W])} >= $past(pageLimit))) |-> respBoundErr);

  // R6
  prot_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    respProtErr |-> $past(lookupWrite));

  // R8
  empty_after_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && $past(flushAll, 2)) |-> !(respHit || respPageFault || respProtErr));

  // R3
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !respHit |-> (respPaddr == '0));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) uChk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
  .lookupWrite(lookupWrite), .pageLimit(pageLimit), .flushAll(flushAll),
  .respValid(respValid), .respPaddr(respPaddr), .respHit(respHit),
  .respMiss(respMiss), .respBoundErr(respBoundErr),
  .respPageFault(respPageFault), .respProtErr(respProtErr)
);

// File: tb/sim_tlb_xlate.sv
`timescale 1ns/1ps
module sim_tlb_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lookupValid = 1'b0;
  logic [15:0] lookupVaddr = '0;
  logic        lookupWrite = 1'b0;
  logic [3:0]  curPid = '0;
  logic [6:0]  pageLimit = 7'd64;
  logic        flushAll = 1'b0;
  logic        refillValid = 1'b0;
  logic [5:0]  refillVpn = '0;
  logic [3:0]  refillPid = '0;
  logic [5:0]  refillPfn = '0;
  logic        refillWritable = 1'b0;
  logic        refillPresent = 1'b0;
  logic        respValid, respHit, respMiss, respBoundErr, respPageFault, respProtErr;
  logic [15:0] respPaddr;

  always #4 clk = ~clk;

  tlb_xlate u0 (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVaddr(lookupVaddr),
    .lookupWrite(lookupWrite), .curPid(curPid), .pageLimit(pageLimit),
    .flushAll(flushAll), .refillValid(refillValid), .refillVpn(refillVpn),
    .refillPid(refillPid), .refillPfn(refillPfn), .refillWritable(refillWritable),
    .refillPresent(refillPresent), .respValid(respValid), .respPaddr(respPaddr),
    .respHit(respHit), .respMiss(respMiss), .respBoundErr(respBoundErr),
    .respPageFault(respPageFault), .respProtErr(respProtErr)
  );

  int nChecks = 0;
  int nFails  = 0;

  // bench model of slot contents
  bit       mUsed [16];
  bit [5:0] mVpn  [16];
  bit [3:0] mPid  [16];
  bit [5:0] mPfn  [16];
  bit       mWr   [16];
  bit       mPres [16];
  int       mRr = 0;

  task automatic check(input bit ok, input string tag, input logic [21:0] act, input logic [21:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelRefill(input bit [5:0] vpn, input bit [3:0] pid, input bit [5:0] pfn,
                             input bit wr, input bit pres);
    int idx = -1;
    for (int i = 0; i < 16; i++) if (idx < 0 && mUsed[i] && mVpn[i] == vpn && mPid[i] == pid) idx = i;
    for (int i = 0; i < 16; i++) if (idx < 0 && !mUsed[i]) idx = i;
    if (idx < 0) begin idx = mRr; mRr = (mRr + 1) % 16; end
    mUsed[idx] = 1; mVpn[idx] = vpn; mPid[idx] = pid; mPfn[idx] = pfn; mWr[idx] = wr; mPres[idx] = pres;
  endtask

  task automatic doRefill(input bit [5:0] vpn, input bit [3:0] pid, input bit [5:0] pfn,
                          input bit wr, input bit pres);
    @(negedge clk);
    refillValid = 1; refillVpn = vpn; refillPid = pid; refillPfn = pfn;
    refillWritable = wr; refillPresent = pres;
    @(posedge clk); #1;
    refillValid = 0;
    modelRefill(vpn, pid, pfn, wr, pres);
  endtask

  // lookup and compare with the model; flags {valid,hit,miss,bound,pf,prot}
  task automatic doLookup(input bit [15:0] va, input bit wr, input bit [3:0] pid, input string extra);
    logic [21:0] exp, act;
    bit [5:0] vpn = va[15:10];
    int idx = -1;
    string tag;
    @(negedge clk);
    lookupValid = 1; lookupVaddr = va; lookupWrite = wr; curPid = pid;
    for (int i = 0; i < 16; i++) if (mUsed[i] && mVpn[i] == vpn && mPid[i] == pid) idx = i;
    if ({1'b0, vpn} >= pageLimit)      begin exp = {6'b100100, 16'h0}; tag = "R4"; end
    else if (idx < 0)                  begin exp = {6'b101000, 16'h0}; tag = "R3"; end
    else if (!mPres[idx])              begin exp = {6'b100010, 16'h0}; tag = "R5"; end
    else if (wr && !mWr[idx])          begin exp = {6'b100001, 16'h0}; tag = "R6"; end
    else begin exp = {6'b110000, mPfn[idx], va[9:0]}; tag = "R1"; end
    @(posedge clk); #1;
    lookupValid = 0;
    act = {respValid, respHit, respMiss, respBoundErr, respPageFault, respProtErr, respPaddr};
    check(act == exp, {tag, " ", extra}, act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [21:0] act;
    repeat (3) @(posedge clk);
    #1;
    act = {respValid, respHit, respMiss, respBoundErr, respPageFault, respProtErr, respPaddr};
    check(act == 22'h0, "R12 outputs low in reset", act, 22'h0);
    @(negedge clk); rstN = 1;
    doLookup(16'h1400, 0, 4'd1, "R12 empty after reset");

    // R10: fill all slots in order
    for (int i = 0; i < 16; i++)
      doRefill(6'(i), 4'd1, 6'((i * 5 + 3) & 63), i[0], i != 7);

    // R7: idle cycle after a lookup
    @(negedge clk); @(posedge clk); #1;
    act = {respValid, respHit, respMiss, respBoundErr, respPageFault, respProtErr, respPaddr};
    check(act == 22'h0, "R7 no result without request", act, 22'h0);

    // sweep every page number, read and write
    for (int v = 0; v < 64; v++)
      for (int w = 0; w < 2; w++)
        doLookup({6'(v), 10'((v * 37 + w * 511) & 1023)}, w[0], 4'd1, "R10 sweep");

    // R2: other process tag
    doLookup({6'd3, 10'd5}, 0, 4'd2, "R2 foreign tag");

    // R4: limit boundary
    pageLimit = 7'd10;
    doLookup({6'd9, 10'd77}, 0, 4'd1, "R4 below limit");
    doLookup({6'd10, 10'd77}, 0, 4'd1, "R4 at limit");
    doLookup({6'd12, 10'd77}, 1, 4'd1, "R4 over limit");
    pageLimit = 7'd64;

    // R9: in-place rewrite
    doRefill(6'd4, 4'd1, 6'd50, 1, 1);
    doLookup({6'd4, 10'd300}, 1, 4'd1, "R9 rewritten in place");
    doLookup({6'd0, 10'd1}, 0, 4'd1, "R9 slot 0 untouched");

    // R11: round-robin replacement and wrap
    doRefill(6'd40, 4'd1, 6'd40, 1, 1);
    doLookup({6'd0, 10'd1}, 0, 4'd1, "R11 slot 0 evicted");
    doLookup({6'd40, 10'd2}, 0, 4'd1, "R11 new entry");
    doRefill(6'd41, 4'd1, 6'd41, 1, 1);
    doLookup({6'd1, 10'd3}, 0, 4'd1, "R11 slot 1 evicted");
    doLookup({6'd2, 10'd4}, 0, 4'd1, "R11 slot 2 kept");
    for (int i = 0; i < 14; i++) doRefill(6'(42 + i), 4'd1, 6'(i), 0, 1);
    doRefill(6'd56, 4'd1, 6'd9, 1, 1);
    doLookup({6'd40, 10'd5}, 0, 4'd1, "R11 wrap evicts slot 0");
    doLookup({6'd41, 10'd6}, 0, 4'd1, "R11 wrap keeps slot 1");
    doLookup({6'd56, 10'd7}, 1, 4'd1, "R11 wrapped entry");

    // R8: flush beats refill
    @(negedge clk);
    flushAll = 1; refillValid = 1; refillVpn = 6'd60; refillPid = 4'd1;
    refillPfn = 6'd60; refillWritable = 1; refillPresent = 1;
    @(posedge clk); #1;
    flushAll = 0; refillValid = 0;
    for (int i = 0; i < 16; i++) mUsed[i] = 0;
    doLookup({6'd60, 10'd8}, 0, 4'd1, "R8 refill dropped");
    doLookup({6'd56, 10'd9}, 0, 4'd1, "R8 flushed");
    doRefill(6'd33, 4'd3, 6'd17, 0, 1);
    doLookup({6'd33, 10'd10}, 0, 4'd3, "R8 refill after flush");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule